// File: doc/BRIEF.md
# Cascaded H-Bridge Phase Level Sequencer

This block drives one phase leg of an N-level cascaded H-bridge inverter built from (N-1)/2 identical three-level cells. For every modulation period an upstream modulator supplies three vertex levels and a dwell count for each of them. The block plays the three levels out as a centred, mirror-symmetric pattern. It then turns the signed phase level of the current cycle into four switch gate signals per cell.

A vertex set enters through a valid/ready port into a single shadow slot. `vtx_ready` is high while the slot is empty. A set is taken on any cycle where `vtx_valid` and `vtx_ready` are both high, and `vtx_ready` then stays low until the next period strobe. While `vtx_ready` is low, the upstream side must hold its data or may withdraw it; nothing is taken. A pulse on `period_start` starts a new period. If the shadow slot is full, its contents become the active set and the slot empties. If the slot is empty, the previous active set is replayed. A set is therefore never applied in the middle of a period.

The block does not change the order of the levels it is given. When two successive output levels differ by more than one cell voltage, it raises a flag and still drives the step as given.

Top module: `chb_phase_seq`

## Requirements
- R1: Each cell occupies a 4-bit group of `gate_o`, with cell c at bits 4c+3..4c and bit order {S4,S3,S2,S1}. A cell at +1 drives 4'b1001 (S1 and S4). A cell at -1 drives 4'b0110 (S2 and S3). A cell at 0 drives either 4'b0101 (S1 and S3) or 4'b1010 (S2 and S4).
- R2: For a level L >= 0, cells 0..L-1 are at +1 and the remaining cells are at 0. For a level L < 0, cells 0..|L|-1 are at -1 and the remaining cells are at 0.
- R3: Zero-holding cells use the S1/S3 pair from reset until the first `period_start`. Each `period_start` pulse swaps the pair for the next period between S1/S3 and S2/S4.
- R4: Let the active set be levels (A,B,C) with dwells (dA,dB,dC). In the cycle after the `period_start` edge, `level_o` begins the following pattern: A for floor(dA/2) cycles, B for floor(dB/2), C for dC, B for dB-floor(dB/2), then A for dA-floor(dA/2). Segments of zero length are skipped. After the pattern ends, `level_o` holds A until the next strobe.
- R5: `step_err` is high in a cycle whose `level_o` differs by more than one from `level_o` in the previous cycle. The previous level counts as 0 just after reset. The level itself is passed through unchanged.
- R6: `vtx_ready` is high whenever the shadow slot is empty. A set is taken when `vtx_valid` and `vtx_ready` are both high, and `vtx_ready` is then low until the cycle after the next `period_start`. A set offered while `vtx_ready` is low is dropped and does not replace the stored one.
- R7: A set taken during a period has no effect on `level_o` or `gate_o` before the next `period_start`. A `period_start` with an empty slot replays the current active set.
- R8: Vertex levels outside ±(N-1)/2 are clamped to the nearest limit when taken, so `level_o` stays within that range. The levels are two's complement, `LW` bits wide.
- R9: After reset `level_o` is 0, every cell drives 4'b0101, `vtx_ready` is 1 and `step_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vtx_valid | input | 1 | Vertex set offered |
| vtx_ready | output | 1 | Shadow slot empty, set can be taken |
| vtx_lvl_a | input | LW | First/outer vertex level, two's complement |
| vtx_lvl_b | input | LW | Second/middle vertex level |
| vtx_lvl_c | input | LW | Third/centre vertex level |
| vtx_dw_a | input | DW | Dwell count of the first vertex |
| vtx_dw_b | input | DW | Dwell count of the second vertex |
| vtx_dw_c | input | DW | Dwell count of the third vertex |
| period_start | input | 1 | One-cycle strobe starting a modulation period |
| level_o | output | LW | Current signed phase level |
| gate_o | output | 4*CELLS | Gate signals, 4 per cell |
| step_err | output | 1 | Level stepped by more than one since the previous cycle |

## Verification
The hardest case to reach from the ports is a new set arriving while a period is still playing out, with the pattern required to stay untouched. The bench causes it in every period: it offers the next set one cycle after each strobe and keeps comparing the running pattern against the previous set. It also sweeps every dwell combination from 0 to 3 for each vertex, which covers odd halves and skipped zero-length segments. The level triples include jumps of two or more, so the step flag is triggered at both inner and period-boundary transitions.

// File: rtl/chb_pkg.sv
`timescale 1ns/1ps
package chb_pkg;
  typedef enum logic [2:0] {
    SEG_A_UP = 3'd0,
    SEG_B_UP = 3'd1,
    SEG_C    = 3'd2,
    SEG_B_DN = 3'd3,
    SEG_A_DN = 3'd4,
    SEG_IDLE = 3'd5
  } seg_e;

  localparam int NSEG = 5;
  localparam int NVTX = 3;

  // nibble order {S4,S3,S2,S1}
  localparam logic [3:0] CELL_POS = 4'b1001;
  localparam logic [3:0] CELL_NEG = 4'b0110;
  localparam logic [3:0] CELL_Z13 = 4'b0101;
  localparam logic [3:0] CELL_Z24 = 4'b1010;
endpackage

// File: rtl/chb_vtx_buf.sv
`timescale 1ns/1ps
module chb_vtx_buf
  import chb_pkg::*;
#(
  parameter int LW   = 3,
  parameter int DW   = 8,
  parameter int HALF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [LW-1:0] in_l  [NVTX],
  input  logic [DW-1:0] in_d  [NVTX],
  input  logic          period_start,
  output logic [LW-1:0] act_l [NVTX],
  output logic [DW-1:0] act_d [NVTX],
  output logic [DW-1:0] nxt_d [NVTX]
);
  logic          full_q;
  logic [LW-1:0] sh_l [NVTX];
  logic [DW-1:0] sh_d [NVTX];
  logic          take;

  function automatic logic [LW-1:0] clamp_lvl(input logic [LW-1:0] v);
    if ($signed(v) < -HALF)     return LW'(-HALF);
    else if ($signed(v) > HALF) return LW'(HALF);
    else                        return v;
  endfunction

  assign in_ready = !full_q;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      for (int i = 0; i < NVTX; i++) begin
        sh_l[i]  <= '0;
        sh_d[i]  <= '0;
        act_l[i] <= '0;
        act_d[i] <= '0;
      end
    end else begin
      if (take)              full_q <= 1'b1;
      else if (period_start) full_q <= 1'b0;
      for (int i = 0; i < NVTX; i++) begin
        if (take) begin
          sh_l[i] <= clamp_lvl(in_l[i]);
          sh_d[i] <= in_d[i];
        end
        if (period_start && full_q) begin
          act_l[i] <= sh_l[i];
          act_d[i] <= sh_d[i];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NVTX; i++) nxt_d[i] = full_q ? sh_d[i] : act_d[i];
  end
endmodule

// File: rtl/chb_seg_seq.sv
`timescale 1ns/1ps
module chb_seg_seq
  import chb_pkg::*;
#(
  parameter int LW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          period_start,
  input  logic [LW-1:0] act_l [NVTX],
  input  logic [DW-1:0] act_d [NVTX],
  input  logic [DW-1:0] nxt_d [NVTX],
  output logic [LW-1:0] level
);
  seg_e          seg_q, start_seg, adv_seg;
  logic [DW-1:0] cnt_q, start_len, adv_len;
  logic [DW-1:0] len_act [NSEG];
  logic [DW-1:0] len_nxt [NSEG];

  function automatic seg_e first_nz(input logic [DW-1:0] lens [NSEG], input int start);
    seg_e r;
    r = SEG_IDLE;
    for (int i = NSEG - 1; i >= 0; i--) begin
      if (i >= start && lens[i] != '0) r = seg_e'(i[2:0]);
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] len_of(input logic [DW-1:0] lens [NSEG], input seg_e s);
    if (s == SEG_IDLE) return '0;
    return lens[int'(s)];
  endfunction

  always_comb begin
    len_act[0] = act_d[0] >> 1;
    len_act[1] = act_d[1] >> 1;
    len_act[2] = act_d[2];
    len_act[3] = act_d[1] - (act_d[1] >> 1);
    len_act[4] = act_d[0] - (act_d[0] >> 1);
    len_nxt[0] = nxt_d[0] >> 1;
    len_nxt[1] = nxt_d[1] >> 1;
    len_nxt[2] = nxt_d[2];
    len_nxt[3] = nxt_d[1] - (nxt_d[1] >> 1);
    len_nxt[4] = nxt_d[0] - (nxt_d[0] >> 1);
    start_seg  = first_nz(len_nxt, 0);
    start_len  = len_of(len_nxt, start_seg);
    adv_seg    = first_nz(len_act, int'(seg_q) + 1);
    adv_len    = len_of(len_act, adv_seg);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q <= SEG_IDLE;
      cnt_q <= '0;
    end else if (period_start) begin
      seg_q <= start_seg;
      cnt_q <= start_len;
    end else if (seg_q != SEG_IDLE) begin
      if (cnt_q > DW'(1)) begin
        cnt_q <= cnt_q - DW'(1);
      end else begin
        seg_q <= adv_seg;
        cnt_q <= adv_len;
      end
    end
  end

  always_comb begin
    case (seg_q)
      SEG_B_UP, SEG_B_DN: level = act_l[1];
      SEG_C:              level = act_l[2];
      default:            level = act_l[0];
    endcase
  end
endmodule

// File: rtl/chb_cell_drv.sv
`timescale 1ns/1ps
module chb_cell_drv
  import chb_pkg::*;
#(
  parameter int LW    = 3,
  parameter int CELLS = 3
) (
  input  logic [LW-1:0]      level,
  input  logic               pair_sel,
  output logic [4*CELLS-1:0] gates
);
  logic          neg;
  logic [LW-1:0] mag;

  assign neg = level[LW-1];
  assign mag = neg ? LW'(-level) : level;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    always_comb begin
      if (c < int'(mag)) gates[4*c +: 4] = neg ? CELL_NEG : CELL_POS;
      else               gates[4*c +: 4] = pair_sel ? CELL_Z24 : CELL_Z13;
    end
  end
endmodule

// File: rtl/chb_phase_seq.sv
`timescale 1ns/1ps
module chb_phase_seq
  import chb_pkg::*;
#(
  parameter  int LEVELS = 7,
  parameter  int DW     = 8,
  localparam int HALF   = (LEVELS - 1) / 2,
  localparam int CELLS  = HALF,
  localparam int LW     = $clog2(HALF + 1) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vtx_valid,
  output logic               vtx_ready,
  input  logic [LW-1:0]      vtx_lvl_a,
  input  logic [LW-1:0]      vtx_lvl_b,
  input  logic [LW-1:0]      vtx_lvl_c,
  input  logic [DW-1:0]      vtx_dw_a,
  input  logic [DW-1:0]      vtx_dw_b,
  input  logic [DW-1:0]      vtx_dw_c,
  input  logic               period_start,
  output logic [LW-1:0]      level_o,
  output logic [4*CELLS-1:0] gate_o,
  output logic               step_err
);
  logic [LW-1:0] in_l  [NVTX];
  logic [DW-1:0] in_d  [NVTX];
  logic [LW-1:0] act_l [NVTX];
  logic [DW-1:0] act_d [NVTX];
  logic [DW-1:0] nxt_d [NVTX];
  logic          pair_q;
  logic [LW-1:0] prev_q;
  logic signed [LW:0] diff;

  assign in_l[0] = vtx_lvl_a;
  assign in_l[1] = vtx_lvl_b;
  assign in_l[2] = vtx_lvl_c;
  assign in_d[0] = vtx_dw_a;
  assign in_d[1] = vtx_dw_b;
  assign in_d[2] = vtx_dw_c;

  chb_vtx_buf #(.LW(LW), .DW(DW), .HALF(HALF)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(vtx_valid), .in_ready(vtx_ready),
    .in_l(in_l), .in_d(in_d), .period_start(period_start),
    .act_l(act_l), .act_d(act_d), .nxt_d(nxt_d)
  );

  chb_seg_seq #(.LW(LW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .period_start(period_start),
    .act_l(act_l), .act_d(act_d), .nxt_d(nxt_d), .level(level_o)
  );

  chb_cell_drv #(.LW(LW), .CELLS(CELLS)) u_drv (
    .level(level_o), .pair_sel(pair_q), .gates(gate_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_q <= 1'b0;
      prev_q <= '0;
    end else begin
      if (period_start) pair_q <= !pair_q;
      prev_q <= level_o;
    end
  end

  assign diff     = $signed({level_o[LW-1], level_o}) - $signed({prev_q[LW-1], prev_q});
  assign step_err = (diff > 1) || (diff < -1);
endmodule

// File: rtl/chb_phase_seq_chk.sv
`timescale 1ns/1ps
module chb_phase_seq_chk
  import chb_pkg::*;
#(
  parameter int LEVELS = 7,
  parameter int HALF   = (LEVELS - 1) / 2,
  parameter int CELLS  = HALF,
  parameter int LW     = $clog2(HALF + 1) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vtx_valid,
  input logic               vtx_ready,
  input logic               period_start,
  input logic [LW-1:0]      level_o,
  input logic [4*CELLS-1:0] gate_o,
  input logic               step_err
);
  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    assert_cell_legs_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_o[4*c +: 4] == CELL_POS) || (gate_o[4*c +: 4] == CELL_NEG) ||
      (gate_o[4*c +: 4] == CELL_Z13) || (gate_o[4*c +: 4] == CELL_Z24));
  end

  assert_level_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(level_o) >= -HALF) && ($signed(level_o) <= HALF));

  assert_ready_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && !(vtx_valid && vtx_ready)) |=> vtx_ready);

  assert_slot_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vtx_valid && vtx_ready) |=> !vtx_ready);

  assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> (!$stable(level_o) || $stable(gate_o)));

  assert_step_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_err |-> (level_o != $past(level_o)));
endmodule

bind chb_phase_seq chb_phase_seq_chk #(.LEVELS(LEVELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .vtx_valid(vtx_valid), .vtx_ready(vtx_ready),
  .period_start(period_start), .level_o(level_o), .gate_o(gate_o), .step_err(step_err)
);

// File: tb/sim_chb_phase_seq.sv
`timescale 1ns/1ps
module sim_chb_phase_seq;
  localparam int LEVELS = 7;
  localparam int DW     = 8;
  localparam int HALF   = 3;
  localparam int CELLS  = 3;
  localparam int LW     = 3;

  logic clk = 1'b0;
  logic rst_n, vtx_valid, vtx_ready, period_start, step_err;
  logic [LW-1:0] vtx_lvl_a, vtx_lvl_b, vtx_lvl_c, level_o;
  logic [DW-1:0] vtx_dw_a, vtx_dw_b, vtx_dw_c;
  logic [4*CELLS-1:0] gate_o;

  int n_chk = 0, n_fail = 0;
  int strobes = 0, prev_lvl = 0;
  int cur_l[3], cur_d[3], pend_l[3], pend_d[3];
  bit pend_full = 0;

  always #4 clk = !clk;

  chb_phase_seq #(.LEVELS(LEVELS), .DW(DW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    if (v < -HALF) return -HALF;
    if (v > HALF) return HALF;
    return v;
  endfunction

  function automatic int exp_level(input int t);
    int a, b, e1, e2, e3, e4;
    a = cur_d[0] / 2; b = cur_d[1] / 2;
    e1 = a; e2 = e1 + b; e3 = e2 + cur_d[2]; e4 = e3 + (cur_d[1] - b);
    if (t < e1) return cur_l[0];
    if (t < e2) return cur_l[1];
    if (t < e3) return cur_l[2];
    if (t < e4) return cur_l[1];
    return cur_l[0];
  endfunction

  function automatic int exp_gates(input int lvl, input int sel);
    int g = 0;
    for (int c = 0; c < CELLS; c++) begin
      int nib;
      if (lvl > 0 && c < lvl)        nib = 4'b1001;
      else if (lvl < 0 && c < -lvl)  nib = 4'b0110;
      else                           nib = sel ? 4'b1010 : 4'b0101;
      g = g | (nib << (4 * c));
    end
    return g;
  endfunction

  function automatic int slv(input logic [LW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic drive_set(input int l[3], input int d[3]);
    vtx_lvl_a = LW'(l[0]); vtx_lvl_b = LW'(l[1]); vtx_lvl_c = LW'(l[2]);
    vtx_dw_a = DW'(d[0]);  vtx_dw_b = DW'(d[1]);  vtx_dw_c = DW'(d[2]);
  endtask

  task automatic push_set(input int l[3], input int d[3]);
    chk(vtx_ready == 1'b1, "R6", int'(vtx_ready), 1);
    drive_set(l, d);
    vtx_valid = 1'b1;
    @(negedge clk);
    vtx_valid = 1'b0;
    chk(vtx_ready == 1'b0, "R6", int'(vtx_ready), 0);
    for (int i = 0; i < 3; i++) begin pend_l[i] = clampv(l[i]); pend_d[i] = d[i]; end
    pend_full = 1;
  endtask

  task automatic run_period(input bit do_push, input int nl[3], input int nd[3]);
    int total;
    period_start = 1'b1;
    @(negedge clk);
    period_start = 1'b0;
    strobes++;
    if (pend_full) begin
      for (int i = 0; i < 3; i++) begin cur_l[i] = pend_l[i]; cur_d[i] = pend_d[i]; end
      pend_full = 0;
    end
    total = cur_d[0] + cur_d[1] + cur_d[2];
    for (int t = 0; t <= total + 1; t++) begin
      int e;
      e = exp_level(t);
      chk(slv(level_o) == e, "R4", slv(level_o), e);
      chk(int'(gate_o) == exp_gates(e, strobes % 2), "R2", int'(gate_o), exp_gates(e, strobes % 2));
      chk(gate_o[3:0] == 4'(exp_gates(e, strobes % 2)), "R1", int'(gate_o[3:0]), exp_gates(e, strobes % 2) & 15);
      if (e > -HALF && e < HALF)
        chk(gate_o[4*CELLS-1 -: 4] == ((strobes % 2) ? 4'b1010 : 4'b0101), "R3",
            int'(gate_o[4*CELLS-1 -: 4]), (strobes % 2) ? 10 : 5);
      chk(step_err == ((e - prev_lvl > 1) || (e - prev_lvl < -1)), "R5", int'(step_err),
          int'((e - prev_lvl > 1) || (e - prev_lvl < -1)));
      prev_lvl = e;
      // R7: the next set is taken mid-period; the pattern above must not change
      if (do_push && t == 0) begin
        chk(vtx_ready == 1'b1, "R6", int'(vtx_ready), 1);
        drive_set(nl, nd);
        vtx_valid = 1'b1;
      end
      if (do_push && t == 1) begin
        chk(vtx_ready == 1'b0, "R7", int'(vtx_ready), 0);
        for (int i = 0; i < 3; i++) begin pend_l[i] = clampv(nl[i]); pend_d[i] = nd[i]; end
        pend_full = 1;
      end
      @(negedge clk);
      if (do_push && t == 0) vtx_valid = 1'b0;
    end
  endtask

  task automatic make_set(input int k, input int idx, output int l[3], output int d[3]);
    l[0] = (k * 3) % 7 - 3;
    l[1] = (k * 5 + 1) % 7 - 3;
    l[2] = (k * 2 + 4) % 7 - 3;
    d[0] = idx % 4;
    d[1] = (idx / 4) % 4;
    d[2] = idx / 16;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int l[3], d[3], nl[3], nd[3];
    rst_n = 1'b0; vtx_valid = 1'b0; period_start = 1'b0;
    vtx_lvl_a = '0; vtx_lvl_b = '0; vtx_lvl_c = '0;
    vtx_dw_a = '0; vtx_dw_b = '0; vtx_dw_c = '0;
    for (int i = 0; i < 3; i++) begin cur_l[i] = 0; cur_d[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(slv(level_o) == 0, "R9", slv(level_o), 0);
    chk(int'(gate_o) == 'h555, "R9", int'(gate_o), 'h555);
    chk(vtx_ready == 1'b1, "R9", int'(vtx_ready), 1);
    chk(step_err == 1'b0, "R9", int'(step_err), 0);

    // sweep: 8 level triples x all dwell triples in 0..3
    make_set(0, 0, l, d);
    push_set(l, d);
    for (int k = 0; k < 8; k++) begin
      for (int idx = 0; idx < 64; idx++) begin
        int nk, ni;
        bit last;
        ni = (idx + 1) % 64;
        nk = (idx == 63) ? k + 1 : k;
        last = (nk == 8);
        make_set(nk, ni, nl, nd);
        run_period(!last, nl, nd);
      end
    end

    // R7: empty slot at strobe replays the current set
    run_period(1'b0, nl, nd);

    // R6: a set offered while the slot is full is dropped
    l[0] = 1; l[1] = 2; l[2] = 3; d[0] = 3; d[1] = 2; d[2] = 1;
    push_set(l, d);
    nl[0] = -3; nl[1] = -3; nl[2] = -3;
    drive_set(nl, d);
    vtx_valid = 1'b1;
    @(negedge clk);
    vtx_valid = 1'b0;
    chk(vtx_ready == 1'b0, "R6", int'(vtx_ready), 0);
    run_period(1'b0, nl, nd);
    chk(slv(level_o) == 1, "R6", slv(level_o), 1);

    // R8: out-of-range level is clamped
    l[0] = -4; l[1] = -4; l[2] = -4; d[0] = 2; d[1] = 2; d[2] = 2;
    push_set(l, d);
    run_period(1'b0, nl, nd);
    chk(slv(level_o) == -3, "R8", slv(level_o), -3);
    chk(int'(gate_o) == 'h666, "R8", int'(gate_o), 'h666);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule